// File: doc/BRIEF.md
# Trace Region Address Matcher

This block decides, one access at a time, whether a bus access should be captured for tracing, and into which trace FIFO. Each traced source (a RAM block or a peripheral frame) owns two programmable regions. A region is described by a truncated start offset and a 4-bit power-of-two size code, with no end bound: a region covers `256 << code` bytes, aligned to its own size. RAM sources compare the low 18 address bits. Peripheral sources compare the low 24 address bits and allow a smaller maximum size.

Regions are loaded through a simple one-cycle register write port that addresses a source and a slot. The access port carries a valid strobe, the address, a write flag and the source index. One cycle later, `trace_hit` pulses and `trace_fifo` names the source's FIFO. Two mode inputs gate the matcher. In trace mode both reads and writes may hit. In direct-data read mode only reads may hit. In direct-data write mode the matcher reports nothing.

Top module: `trace_region_matcher`

## Requirements
- R1: While reset is high and after reset, every region is disabled and `trace_hit` is 0 until a region is programmed.
- R2: A write with `cfg_we` high stores start, size code, enable and access selection into region slot `cfg_slot` of source `cfg_src`. The stored region takes effect for accesses presented from the next cycle on.
- R3: An access presented with `acc_valid` high yields its result on `trace_hit` one clock later. When `trace_hit` is 1, `trace_fifo` equals the `acc_src` of that access.
- R4: For a RAM source, only `acc_addr[17:0]` and `cfg_start[17:0]` take part in the compare. Higher address bits are ignored.
- R5: For a peripheral source, `acc_addr[23:0]` and `cfg_start[23:0]` take part in the compare. Bits above 23 are ignored.
- R6: A region with size code c covers `256 << c` bytes. The offset hits when it lies in `[base, base + size)`, where `base` is the start with its low `8 + c` bits cleared.
- R7: The largest legal code is 10 (256 KB) for RAM and 9 (128 KB) for peripherals. A larger code makes the region never hit.
- R8: A region whose enable bit is 0 never hits.
- R9: Access selection bit 0 permits reads and bit 1 permits writes. An access hits a region only if the bit for its type is set.
- R10: With `trace_mode` = 1, both reads and writes can hit, and `ddm_write` has no effect.
- R11: With `trace_mode` = 0 and `ddm_write` = 0, only reads can hit.
- R12: With `trace_mode` = 0 and `ddm_write` = 1, no access hits.
- R13: When both regions of the addressed source match, a single one-cycle hit for that source's FIFO is reported.
- R14: With `acc_valid` low, `trace_hit` is 0 on the next cycle, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_mode | input | 1 | 1 = trace mode, 0 = direct-data mode |
| ddm_write | input | 1 | In direct-data mode: 1 = write capture (matcher off), 0 = read capture |
| cfg_we | input | 1 | Region register write strobe |
| cfg_src | input | SRC_W (2) | Source whose region is written |
| cfg_slot | input | 1 | Region slot (0 or 1) within the source |
| cfg_start | input | 24 | Region start offset |
| cfg_size | input | 4 | Size code, size = 256 << code |
| cfg_en | input | 1 | Region enable |
| cfg_rw | input | 2 | Access selection: bit 0 reads, bit 1 writes |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_src | input | SRC_W (2) | Source the access targets |
| trace_hit | output | 1 | Access is to be traced (one cycle after the access) |
| trace_fifo | output | SRC_W (2) | FIFO index for the traced access |

## Verification
Directed accesses probe the exact edges of a region: the first byte, the last byte, one byte past the end, and one byte before the start. Together these tell a correct half-open range from an off-by-one range or a wrong mask width. Other directed accesses flip address bits just above 17 and just above 23, which separates the RAM offset width from the peripheral one. Further cases step the size code across each source's legal limit. Randomly programmed regions, with addresses drawn from a window around each region and random upper bits, run under all three mode settings with mixed reads and writes. They show whether the mode gating, the access-type selection and the overlapping-region merge agree with an independent range-arithmetic model.

// File: rtl/trm_pkg.sv
package trm_pkg;

    localparam int BLK_LSB      = 8;
    localparam int RAM_OFS_W    = 18;
    localparam int PER_OFS_W    = 24;
    localparam int RAM_MAX_CODE = 10;
    localparam int PER_MAX_CODE = 9;
    localparam int CODE_W       = 4;
    localparam int RW_W         = 2;
    localparam int SLOTS        = 2;
    localparam int SLOT_W       = 1;
    localparam int ADDR_W       = 32;

    typedef enum logic [RW_W-1:0] {
        RW_NONE = 2'b00,
        RW_RD   = 2'b01,
        RW_WR   = 2'b10,
        RW_BOTH = 2'b11
    } rw_sel_e;

    typedef struct packed {
        logic                  en;
        rw_sel_e               rw;
        logic [CODE_W-1:0]     code;
        logic [PER_OFS_W-1:0]  start;
    } region_cfg_t;

    function automatic int ofs_width(input logic is_per);
        return is_per ? PER_OFS_W : RAM_OFS_W;
    endfunction

    function automatic int max_code(input logic is_per);
        return is_per ? PER_MAX_CODE : RAM_MAX_CODE;
    endfunction

    // Aligned block compare: bits below the block size and above the
    // source's offset width take no part.
    function automatic logic block_match(
        input logic [PER_OFS_W-1:0] start,
        input logic [PER_OFS_W-1:0] ofs,
        input logic [CODE_W-1:0]    code,
        input logic                 is_per
    );
        logic m;
        int   lo;
        int   w;
        m  = 1'b1;
        lo = BLK_LSB + int'(code);
        w  = ofs_width(is_per);
        if (int'(code) > max_code(is_per)) begin
            m = 1'b0;
        end else begin
            for (int i = 0; i < PER_OFS_W; i++) begin
                if (i >= lo && i < w && start[i] != ofs[i]) m = 1'b0;
            end
        end
        return m;
    endfunction

    function automatic logic type_allowed(input rw_sel_e rw, input logic is_write);
        return is_write ? rw[1] : rw[0];
    endfunction

endpackage

// File: rtl/trm_region_bank.sv
module trm_region_bank
    import trm_pkg::*;
#(
    parameter int NUM_REG = 8,
    localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  region_cfg_t                wcfg,
    output region_cfg_t [NUM_REG-1:0]  cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REG; i++) cfg_q[i] <= '0;
        end else if (we && int'(widx) < NUM_REG) begin
            cfg_q[widx] <= wcfg;
        end
    end

    // R1: no enabled region may survive a reset
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (cfg_q[0].en == 1'b0));

endmodule

// File: rtl/trm_region_cmp.sv
module trm_region_cmp
    import trm_pkg::*;
#(
    parameter logic IS_PER = 1'b0
)(
    input  logic                  clk,
    input  logic                  rst,
    input  region_cfg_t           cfg,
    input  logic [PER_OFS_W-1:0]  ofs,
    input  logic                  is_write,
    output logic                  match
);

    logic in_block;
    logic type_ok;

    always_comb begin
        in_block = block_match(cfg.start, ofs, cfg.code, IS_PER);
        type_ok  = type_allowed(cfg.rw, is_write);
        match    = cfg.en && in_block && type_ok;
    end

    // R8: a disabled region never reports a match
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !match);

    // R7: an oversize code never reports a match
    a_r7_code_limit: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg.code) > max_code(IS_PER)) |-> !match);

    // R9: access selection must permit the access type
    a_r9_type_gate: assert property (@(posedge clk) disable iff (rst)
        (is_write && !cfg.rw[1]) |-> !match);

endmodule

// File: rtl/trace_region_matcher.sv
module trace_region_matcher
    import trm_pkg::*;
#(
    parameter int                 NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] SRC_IS_PER = 4'b1100,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int NUM_REG = NUM_SRC * SLOTS,
    localparam int IDX_W   = SRC_W + SLOT_W
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trace_mode,
    input  logic                  ddm_write,
    input  logic                  cfg_we,
    input  logic [SRC_W-1:0]      cfg_src,
    input  logic                  cfg_slot,
    input  logic [PER_OFS_W-1:0]  cfg_start,
    input  logic [CODE_W-1:0]     cfg_size,
    input  logic                  cfg_en,
    input  logic [RW_W-1:0]       cfg_rw,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_write,
    input  logic [SRC_W-1:0]      acc_src,
    output logic                  trace_hit,
    output logic [SRC_W-1:0]      trace_fifo
);

    region_cfg_t                wcfg;
    region_cfg_t [NUM_REG-1:0]  regs;
    logic        [IDX_W-1:0]    widx;
    logic        [PER_OFS_W-1:0] acc_ofs;
    logic        [NUM_REG-1:0]  reg_match;
    logic        [NUM_SRC-1:0]  src_hit;
    logic                       mode_ok;
    logic                       hit_d;

    always_comb begin
        wcfg.en    = cfg_en;
        wcfg.rw    = rw_sel_e'(cfg_rw);
        wcfg.code  = cfg_size;
        wcfg.start = cfg_start;
        widx       = {cfg_src, cfg_slot};
        acc_ofs    = acc_addr[PER_OFS_W-1:0];
    end

    trm_region_bank #(.NUM_REG(NUM_REG)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (widx),
        .wcfg  (wcfg),
        .cfg_q (regs)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar r = 0; r < SLOTS; r++) begin : g_slot
            trm_region_cmp #(.IS_PER(SRC_IS_PER[s])) u_cmp (
                .clk      (clk),
                .rst      (rst),
                .cfg      (regs[s*SLOTS + r]),
                .ofs      (acc_ofs),
                .is_write (acc_write),
                .match    (reg_match[s*SLOTS + r])
            );
        end
        assign src_hit[s] = |reg_match[s*SLOTS +: SLOTS];
    end

    // Mode gate: trace mode passes both types, direct-data read passes
    // reads only, direct-data write passes nothing.
    always_comb begin
        if (trace_mode)     mode_ok = 1'b1;
        else if (ddm_write) mode_ok = 1'b0;
        else                mode_ok = !acc_write;
        hit_d = acc_valid && mode_ok && (int'(acc_src) < NUM_SRC) && src_hit[acc_src];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trace_hit  <= 1'b0;
            trace_fifo <= '0;
        end else begin
            trace_hit  <= hit_d;
            trace_fifo <= acc_src;
        end
    end

    // R14: idle cycles never produce a hit
    a_r14_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !trace_hit);

    // R12: direct-data write mode keeps the matcher silent
    a_r12_ddm_write_silent: assert property (@(posedge clk) disable iff (rst)
        (!trace_mode && ddm_write) |=> !trace_hit);

    // R11: direct-data read mode never traces writes
    a_r11_ddm_reads_only: assert property (@(posedge clk) disable iff (rst)
        (!trace_mode && acc_write) |=> !trace_hit);

    // R3: the FIFO index follows the access source
    a_r3_fifo_follows_src: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (!trace_hit || trace_fifo == $past(acc_src)));

endmodule

// File: tb/trace_region_matcher_test.sv
module trace_region_matcher_test;
    localparam int NUM_SRC = 4;
    localparam logic [NUM_SRC-1:0] IS_PER = 4'b1100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_mode = 1'b1, ddm_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_src = '0;
    logic        cfg_slot = 1'b0;
    logic [23:0] cfg_start = '0;
    logic [3:0]  cfg_size = '0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_rw = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_src = '0;
    logic        trace_hit;
    logic [1:0]  trace_fifo;

    int checks = 0, errors = 0;

    // bench model of the region registers
    bit          m_en [8];
    bit [1:0]    m_rw [8];
    int unsigned m_code [8];
    int unsigned m_start [8];
    bit          m_tm = 1'b1, m_dw = 1'b0;

    always #2 clk = ~clk;

    trace_region_matcher uut (
        .clk(clk), .rst(rst), .trace_mode(trace_mode), .ddm_write(ddm_write),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_slot(cfg_slot),
        .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_en(cfg_en), .cfg_rw(cfg_rw),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_src(acc_src), .trace_hit(trace_hit), .trace_fifo(trace_fifo)
    );

    function automatic bit region_hits(int idx, int src, int unsigned addr, bit wr);
        int unsigned w, maxc, wmask, ofs, size, base;
        w     = IS_PER[src] ? 24 : 18;
        maxc  = IS_PER[src] ? 9 : 10;
        if (!m_en[idx] || m_code[idx] > maxc) return 1'b0;
        if (wr ? !m_rw[idx][1] : !m_rw[idx][0]) return 1'b0;
        wmask = (32'd1 << w) - 1;
        ofs   = addr & wmask;
        size  = 32'd256 << m_code[idx];
        base  = (m_start[idx] & wmask) & ~(size - 1);
        return (ofs >= base) && (ofs < base + size);
    endfunction

    function automatic bit exp_hit(int src, int unsigned addr, bit wr, bit valid);
        if (!valid) return 1'b0;
        if (!m_tm && m_dw) return 1'b0;
        if (!m_tm && wr) return 1'b0;
        return region_hits(src*2, src, addr, wr) || region_hits(src*2+1, src, addr, wr);
    endfunction

    task automatic set_region(int src, int slot, int unsigned start, int code, bit en, bit [1:0] rw);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = 2'(src); cfg_slot = slot[0];
        cfg_start = start[23:0]; cfg_size = 4'(code); cfg_en = en; cfg_rw = rw;
        m_en[src*2+slot] = en; m_rw[src*2+slot] = rw;
        m_code[src*2+slot] = code; m_start[src*2+slot] = start & 32'hFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(bit tm, bit dw);
        @(negedge clk);
        trace_mode = tm; ddm_write = dw; m_tm = tm; m_dw = dw;
    endtask

    // drive one access at a negedge, check the registered result one clock later
    task automatic access(int src, int unsigned addr, bit wr, bit valid, string tag);
        bit e;
        @(negedge clk);
        acc_valid = valid; acc_src = 2'(src); acc_addr = addr; acc_write = wr;
        e = exp_hit(src, addr, wr, valid);
        @(negedge clk);
        acc_valid = 1'b0;
        checks++;
        if (trace_hit !== e || (e && trace_fifo !== 2'(src))) begin
            errors++;
            $display("FAIL %s: src %0d addr %h wr %0d hit %0b fifo %0d, expected hit %0b fifo %0d",
                     tag, src, addr, wr, trace_hit, trace_fifo, e, src);
        end
    endtask

    task automatic expect_hit(bit want, string tag);
        checks++;
        if (trace_hit !== want) begin
            errors++;
            $display("FAIL %s: hit %0b expected %0b", tag, trace_hit, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        expect_hit(1'b0, "R1 during reset");
        rst = 1'b0;
        access(0, 32'h0000_0000, 1'b0, 1'b1, "R1 after reset");

        // RAM source 0, slot 0: 1 KB at 0x1000
        set_region(0, 0, 32'h0_1000, 2, 1'b1, 2'b11);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R2 first byte");
        access(0, 32'h0000_13FF, 1'b0, 1'b1, "R6 last byte");
        access(0, 32'h0000_1400, 1'b0, 1'b1, "R6 one past end");
        access(0, 32'h0000_0FFF, 1'b0, 1'b1, "R6 before start");
        access(1, 32'h0000_1000, 1'b0, 1'b1, "R3 other source");
        set_region(0, 0, 32'h0_1234, 2, 1'b1, 2'b11);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R6 low start bits ignored");
        access(0, 32'hABC0_1100, 1'b1, 1'b1, "R4 RAM upper bits ignored");
        access(0, 32'h0004_1100, 1'b0, 1'b1, "R4 RAM bit 18 ignored");

        // peripheral source 2, slot 1: 256 B at 0x340000
        set_region(2, 1, 32'h34_0000, 0, 1'b1, 2'b11);
        access(2, 32'h0034_0010, 1'b0, 1'b1, "R5 peripheral hit");
        access(2, 32'h0024_0010, 1'b0, 1'b1, "R5 peripheral bit 20 compared");
        access(2, 32'hFF34_0010, 1'b0, 1'b1, "R5 peripheral bit 24 ignored");

        // size code limits
        set_region(1, 0, 32'h0, 10, 1'b1, 2'b11);
        access(1, 32'h0003_FFFF, 1'b0, 1'b1, "R7 RAM code 10 legal");
        set_region(1, 0, 32'h0, 11, 1'b1, 2'b11);
        access(1, 32'h0000_0010, 1'b0, 1'b1, "R7 RAM code 11 off");
        set_region(3, 0, 32'h0, 9, 1'b1, 2'b11);
        access(3, 32'h0001_FFFF, 1'b0, 1'b1, "R7 peripheral code 9 last byte");
        access(3, 32'h0002_0000, 1'b0, 1'b1, "R7 peripheral code 9 past end");
        set_region(3, 0, 32'h0, 10, 1'b1, 2'b11);
        access(3, 32'h0000_0010, 1'b0, 1'b1, "R7 peripheral code 10 off");

        // enable and access selection
        set_region(0, 0, 32'h0_1000, 2, 1'b0, 2'b11);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R8 disabled region");
        set_region(0, 0, 32'h0_1000, 2, 1'b1, 2'b01);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R9 read permitted");
        access(0, 32'h0000_1000, 1'b1, 1'b1, "R9 write refused");
        set_region(0, 0, 32'h0_1000, 2, 1'b1, 2'b10);
        access(0, 32'h0000_1000, 1'b1, 1'b1, "R9 write permitted");
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R9 read refused");
        set_region(0, 0, 32'h0_1000, 2, 1'b1, 2'b11);
        set_mode(1'b1, 1'b1);
        access(0, 32'h0000_1000, 1'b1, 1'b1, "R10 trace mode write");
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R10 trace mode read");

        // direct-data modes
        set_mode(1'b0, 1'b0);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R11 ddm read traced");
        access(0, 32'h0000_1000, 1'b1, 1'b1, "R11 ddm write refused");
        set_mode(1'b0, 1'b1);
        access(0, 32'h0000_1000, 1'b0, 1'b1, "R12 ddm write mode silent");
        set_mode(1'b1, 1'b0);

        // overlapping regions on source 1: one pulse
        set_region(1, 0, 32'h0_5000, 4, 1'b1, 2'b11);
        set_region(1, 1, 32'h0_5000, 0, 1'b1, 2'b11);
        access(1, 32'h0000_5010, 1'b0, 1'b1, "R13 both regions match");
        @(negedge clk);
        expect_hit(1'b0, "R13 single pulse");
        access(1, 32'h0000_5010, 1'b0, 1'b0, "R14 idle matching address");

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            pick = $urandom_range(0, 99);
            if (pick < 8) begin
                set_region($urandom_range(0, 3), $urandom_range(0, 1), $urandom,
                           $urandom_range(0, 12), ($urandom_range(0, 9) < 8), 2'($urandom));
            end else if (pick < 12) begin
                set_mode(($urandom_range(0, 2) != 0), 1'($urandom));
            end else begin
                int src, idx;
                int unsigned w, wmask, size, ofs, addr;
                src   = $urandom_range(0, 3);
                idx   = src*2 + $urandom_range(0, 1);
                w     = IS_PER[src] ? 24 : 18;
                wmask = (32'd1 << w) - 1;
                size  = 32'd256 << (m_code[idx] > 12 ? 12 : m_code[idx]);
                ofs   = ((m_start[idx] & ~(size - 1)) + ($urandom % (3*size)) - size) & wmask;
                addr  = ($urandom & ~wmask) | ofs;
                access(src, addr, 1'($urandom), ($urandom_range(0, 9) != 0), "R3/R6 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule